// File: doc/BRIEF.md
# Timer Channel Byte Access Port

This block sits between an 8-bit register bus and a bank of three 16-bit timer channels. The bus sees four byte addresses. Addresses 0 to 2 belong to the channels and carry count bytes in both directions. Address 3 accepts control words only. A control word either reprograms one channel or asks for a snapshot of a channel's count. A multi-channel snapshot command can also capture the count, the status, or both.

The port turns 16-bit counts into byte sequences. A channel can be set to low byte only, high byte only, or low-then-high. Reads and writes keep separate byte phases. A held count snapshot and a held status snapshot each last until software has read them. Status is always read before a held count, and a held count before the live value.

On the channel side, the port issues a one-cycle load strobe with a 16-bit value. It also drives each channel's mode and decimal-counting flag. It takes in the live counts, the output levels and a "count transferred" indication. The counting engines themselves live outside this block.

Top module: `tmr_byte_port`

## Requirements
- R1: After reset, every channel is in low-then-high access with mode 0, decimal flag 0, no held snapshots and null-count 0. Reads of address 3 always return 0x00.
- R2: A write to address 3 with bits 7:6 = c (0..2) and bits 5:4 != 0 sets channel c's access (1 low only, 2 high only, 3 low-then-high), its mode (bits 3:1; 6 and 7 become 2 and 3) and its decimal flag (bit 0). It also resets that channel's read and write byte phases. Mode and decimal outputs change only on such writes.
- R3: In low-only access, a data write loads {0x00, byte}. In high-only access, it loads {byte, 0x00}. The channel's load strobe and the value appear for exactly one cycle, in the cycle after the write.
- R4: In low-then-high access, the first data byte is held with no load. The second byte loads {second, first}.
- R5: Without held snapshots, reads return the live count: the low byte, the high byte, or in low-then-high access alternately the low and then the high byte.
- R6: A write to address 3 with bits 7:6 = c and bits 5:4 = 0 captures channel c's count. Reads then return it according to the access in force at capture time: one byte, or low then high. After that the snapshot is released and reads are live again.
- R7: A count capture for a channel whose previous snapshot is not fully read is ignored.
- R8: A write to address 3 with bits 7:6 = 3 is a snapshot command. Bits 1, 2 and 3 select channels 0, 1 and 2. Bit 5 = 0 captures the counts and bit 4 = 0 captures the statuses of all selected channels.
- R9: The status byte is {out level (bit 7), null-count (bit 6), access (bits 5:4), mode (bits 3:1), decimal (bit 0)}, taken at command time. A held status is returned by the next read, ahead of any held count.
- R10: A status capture for a channel whose held status has not been read is ignored.
- R11: Null-count is set by a control word to the channel and by a count load. It is cleared when the channel reports the count as transferred.
- R12: In low-then-high access, the read and write byte phases advance independently of each other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Bus write strobe |
| rd_en_i | input | 1 | Bus read strobe (read side effects at the clock edge) |
| addr_i | input | ADDR_W | Byte address: 0..2 channel data, 3 control |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for addr_i (combinational) |
| ld_o | output | NUM_CH | Per-channel count load strobe |
| ld_val_o | output | 16 | Value for the strobed channel |
| mode_o | output | 3*NUM_CH | Per-channel mode |
| bcd_o | output | NUM_CH | Per-channel decimal-counting flag |
| cnt_i | input | 16*NUM_CH | Live count of each channel |
| out_i | input | NUM_CH | Output level of each channel |
| loaded_i | input | NUM_CH | Channel has taken over its new count |

## Verification
The bench sweeps every legal control word: all channels, all three access codes, all eight mode codes and both decimal values. Each word is read back through a status snapshot, which separates mode folding, field placement and null-count behaviour. For each access code, the data-write patterns tell apart the low-only placement, the high-only placement and the held-first-byte word load. Directed sequences interleave live reads, writes and snapshot commands. These expose shared or reset byte phases, snapshots that are overwritten while pending, and a wrong order between status, held count and live count.

// File: rtl/tmr_port_pkg.sv
package tmr_port_pkg;
  localparam int BYTE_W = 8;
  localparam int CNT_W  = 2 * BYTE_W;
  localparam int MODE_W = 3;

  typedef enum logic [1:0] {
    ACC_NONE = 2'd0,
    ACC_LO   = 2'd1,
    ACC_HI   = 2'd2,
    ACC_WORD = 2'd3
  } acc_e;

  typedef struct packed {
    acc_e              acc;
    logic [MODE_W-1:0] mode;
    logic              bcd;
  } chan_cfg_t;

  localparam chan_cfg_t CFG_RST = '{acc: ACC_WORD, mode: '0, bcd: 1'b0};

  // codes 6 and 7 alias the periodic modes 2 and 3
  function automatic logic [MODE_W-1:0] fold_mode(input logic [MODE_W-1:0] m);
    return (m[2] && m[1]) ? {1'b0, m[1:0]} : m;
  endfunction
endpackage

// File: rtl/tp_ctrl_dec.sv
module tp_ctrl_dec
  import tmr_port_pkg::*;
#(
  parameter int NUM_CH = 3,
  parameter int ADDR_W = 2
) (
  input  logic                  wr_en_i,
  input  logic                  rd_en_i,
  input  logic [ADDR_W-1:0]     addr_i,
  input  logic [BYTE_W-1:0]     wdata_i,
  output chan_cfg_t             cfg_o,
  output logic [NUM_CH-1:0]     cfg_we_o,
  output logic [NUM_CH-1:0]     cnt_lat_o,
  output logic [NUM_CH-1:0]     sts_lat_o,
  output logic [NUM_CH-1:0]     dat_we_o,
  output logic [NUM_CH-1:0]     dat_re_o
);
  localparam logic [ADDR_W-1:0] CTRL_ADDR = ADDR_W'(NUM_CH);
  localparam logic [1:0]        SEL_RB    = 2'd3;

  logic       ctl_wr;
  logic [1:0] sel;
  logic       is_rb;
  logic       acc_zero;

  always_comb begin
    ctl_wr     = wr_en_i && (addr_i == CTRL_ADDR);
    sel        = wdata_i[7:6];
    is_rb      = (sel == SEL_RB);
    acc_zero   = (wdata_i[5:4] == 2'd0);
    cfg_o.acc  = acc_e'(wdata_i[5:4]);
    cfg_o.mode = fold_mode(wdata_i[3:1]);
    cfg_o.bcd  = wdata_i[0];
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    localparam int RB_BIT = c + 1;
    logic hit, rb_hit;
    assign hit          = ctl_wr && !is_rb && (sel == 2'(c));
    assign rb_hit       = ctl_wr && is_rb && wdata_i[RB_BIT];
    assign cfg_we_o[c]  = hit && !acc_zero;
    assign cnt_lat_o[c] = (hit && acc_zero) || (rb_hit && !wdata_i[5]);
    assign sts_lat_o[c] = rb_hit && !wdata_i[4];
    assign dat_we_o[c]  = wr_en_i && (addr_i == ADDR_W'(c));
    assign dat_re_o[c]  = rd_en_i && (addr_i == ADDR_W'(c));
  end
endmodule

// File: rtl/tp_chan.sv
module tp_chan
  import tmr_port_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_we_i,
  input  chan_cfg_t         cfg_i,
  input  logic              cnt_lat_i,
  input  logic              sts_lat_i,
  input  logic              dat_we_i,
  input  logic              dat_re_i,
  input  logic [BYTE_W-1:0] wdata_i,
  input  logic [CNT_W-1:0]  cnt_i,
  input  logic              out_i,
  input  logic              loaded_i,
  output chan_cfg_t         cfg_o,
  output logic [BYTE_W-1:0] rdata_o,
  output logic              ld_o,
  output logic [CNT_W-1:0]  ld_val_o
);
  chan_cfg_t         cfg_q;
  logic              wr_hi_q, rd_hi_q;
  logic [BYTE_W-1:0] hold_q;
  acc_e              lat_st_q;
  logic [CNT_W-1:0]  lat_cnt_q;
  logic              sts_vld_q;
  logic [BYTE_W-1:0] sts_q;
  logic              null_q;
  logic              ld_q;
  logic [CNT_W-1:0]  ld_val_q;

  logic              load_now;
  logic [CNT_W-1:0]  load_val;

  always_comb begin
    load_now = 1'b0;
    load_val = '0;
    if (dat_we_i) begin
      unique case (cfg_q.acc)
        ACC_LO: begin
          load_now = 1'b1;
          load_val = {{BYTE_W{1'b0}}, wdata_i};
        end
        ACC_HI: begin
          load_now = 1'b1;
          load_val = {wdata_i, {BYTE_W{1'b0}}};
        end
        ACC_WORD: begin
          load_now = wr_hi_q;
          load_val = {wdata_i, hold_q};
        end
        default: ;
      endcase
    end
  end

  always_comb begin
    rdata_o = '0;
    if (sts_vld_q) begin
      rdata_o = sts_q;
    end else if (lat_st_q != ACC_NONE) begin
      rdata_o = (lat_st_q == ACC_HI) ? lat_cnt_q[CNT_W-1:BYTE_W] : lat_cnt_q[BYTE_W-1:0];
    end else begin
      unique case (cfg_q.acc)
        ACC_HI:   rdata_o = cnt_i[CNT_W-1:BYTE_W];
        ACC_WORD: rdata_o = rd_hi_q ? cnt_i[CNT_W-1:BYTE_W] : cnt_i[BYTE_W-1:0];
        default:  rdata_o = cnt_i[BYTE_W-1:0];
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q     <= CFG_RST;
      wr_hi_q   <= 1'b0;
      rd_hi_q   <= 1'b0;
      hold_q    <= '0;
      lat_st_q  <= ACC_NONE;
      lat_cnt_q <= '0;
      sts_vld_q <= 1'b0;
      sts_q     <= '0;
      null_q    <= 1'b0;
      ld_q      <= 1'b0;
      ld_val_q  <= '0;
    end else begin
      ld_q <= load_now;
      if (load_now) ld_val_q <= load_val;

      // read side effects, highest-priority source consumed first
      if (dat_re_i) begin
        if (sts_vld_q) begin
          sts_vld_q <= 1'b0;
        end else if (lat_st_q != ACC_NONE) begin
          lat_st_q <= (lat_st_q == ACC_WORD) ? ACC_HI : ACC_NONE;
        end else if (cfg_q.acc == ACC_WORD) begin
          rd_hi_q <= !rd_hi_q;
        end
      end

      if (dat_we_i && (cfg_q.acc == ACC_WORD)) begin
        if (!wr_hi_q) hold_q <= wdata_i;
        wr_hi_q <= !wr_hi_q;
      end

      // a control word restarts both byte phases
      if (cfg_we_i) begin
        cfg_q   <= cfg_i;
        wr_hi_q <= 1'b0;
        rd_hi_q <= 1'b0;
      end

      if (cnt_lat_i && (lat_st_q == ACC_NONE)) begin
        lat_cnt_q <= cnt_i;
        lat_st_q  <= cfg_q.acc;
      end

      if (sts_lat_i && !sts_vld_q) begin
        sts_q     <= {out_i, null_q, cfg_q.acc, cfg_q.mode, cfg_q.bcd};
        sts_vld_q <= 1'b1;
      end

      if (cfg_we_i || load_now) null_q <= 1'b1;
      else if (loaded_i)        null_q <= 1'b0;
    end
  end

  assign cfg_o    = cfg_q;
  assign ld_o     = ld_q;
  assign ld_val_o = ld_val_q;
endmodule

// File: rtl/tp_out_mux.sv
module tp_out_mux
  import tmr_port_pkg::*;
#(
  parameter int NUM_CH = 3,
  parameter int ADDR_W = 2
) (
  input  logic [ADDR_W-1:0]             addr_i,
  input  logic [NUM_CH-1:0][BYTE_W-1:0] ch_rdata_i,
  input  logic [NUM_CH-1:0]             ld_i,
  input  logic [NUM_CH-1:0][CNT_W-1:0]  ch_ld_val_i,
  output logic [BYTE_W-1:0]             rdata_o,
  output logic [CNT_W-1:0]              ld_val_o
);
  always_comb begin
    rdata_o  = '0;
    ld_val_o = '0;
    for (int c = 0; c < NUM_CH; c++) begin
      if (addr_i == ADDR_W'(c)) rdata_o = ch_rdata_i[c];
      if (ld_i[c]) ld_val_o = ld_val_o | ch_ld_val_i[c];
    end
  end
endmodule

// File: rtl/tmr_byte_port.sv
module tmr_byte_port
  import tmr_port_pkg::*;
#(
  parameter int NUM_CH = 3,
  parameter int ADDR_W = 2
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     wr_en_i,
  input  logic                     rd_en_i,
  input  logic [ADDR_W-1:0]        addr_i,
  input  logic [BYTE_W-1:0]        wdata_i,
  output logic [BYTE_W-1:0]        rdata_o,
  output logic [NUM_CH-1:0]        ld_o,
  output logic [CNT_W-1:0]         ld_val_o,
  output logic [MODE_W*NUM_CH-1:0] mode_o,
  output logic [NUM_CH-1:0]        bcd_o,
  input  logic [CNT_W*NUM_CH-1:0]  cnt_i,
  input  logic [NUM_CH-1:0]        out_i,
  input  logic [NUM_CH-1:0]        loaded_i
);
  chan_cfg_t                     new_cfg;
  logic [NUM_CH-1:0]             cfg_we, cnt_lat, sts_lat, dat_we, dat_re;
  logic [NUM_CH-1:0][BYTE_W-1:0] ch_rdata;
  logic [NUM_CH-1:0][CNT_W-1:0]  ch_ld_val;

  tp_ctrl_dec #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) i_dec (
    .wr_en_i  (wr_en_i),
    .rd_en_i  (rd_en_i),
    .addr_i   (addr_i),
    .wdata_i  (wdata_i),
    .cfg_o    (new_cfg),
    .cfg_we_o (cfg_we),
    .cnt_lat_o(cnt_lat),
    .sts_lat_o(sts_lat),
    .dat_we_o (dat_we),
    .dat_re_o (dat_re)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    chan_cfg_t cfg;
    tp_chan i_chan (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .cfg_we_i (cfg_we[c]),
      .cfg_i    (new_cfg),
      .cnt_lat_i(cnt_lat[c]),
      .sts_lat_i(sts_lat[c]),
      .dat_we_i (dat_we[c]),
      .dat_re_i (dat_re[c]),
      .wdata_i  (wdata_i),
      .cnt_i    (cnt_i[c*CNT_W +: CNT_W]),
      .out_i    (out_i[c]),
      .loaded_i (loaded_i[c]),
      .cfg_o    (cfg),
      .rdata_o  (ch_rdata[c]),
      .ld_o     (ld_o[c]),
      .ld_val_o (ch_ld_val[c])
    );
    assign mode_o[c*MODE_W +: MODE_W] = cfg.mode;
    assign bcd_o[c]                   = cfg.bcd;
  end

  tp_out_mux #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) i_mux (
    .addr_i     (addr_i),
    .ch_rdata_i (ch_rdata),
    .ld_i       (ld_o),
    .ch_ld_val_i(ch_ld_val),
    .rdata_o    (rdata_o),
    .ld_val_o   (ld_val_o)
  );
endmodule

// File: rtl/tmr_byte_port_chk.sv
module tmr_byte_port_chk
  import tmr_port_pkg::*;
#(
  parameter int NUM_CH = 3,
  parameter int ADDR_W = 2
) (
  input logic                     clk_i,
  input logic                     rst_ni,
  input logic                     wr_en_i,
  input logic [ADDR_W-1:0]        addr_i,
  input logic [BYTE_W-1:0]        rdata_o,
  input logic [NUM_CH-1:0]        ld_o,
  input logic [MODE_W*NUM_CH-1:0] mode_o,
  input logic [NUM_CH-1:0]        bcd_o
);
  localparam logic [ADDR_W-1:0] CTRL_ADDR = ADDR_W'(NUM_CH);

  AST_CTRL_READ_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i == CTRL_ADDR) |-> (rdata_o == '0)); // R1

  AST_LOAD_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(ld_o)); // R3

  AST_LOAD_AFTER_DATA_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|ld_o) |-> $past(wr_en_i && (addr_i != CTRL_ADDR))); // R3

  AST_CFG_ONLY_ON_CTRL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_en_i && (addr_i == CTRL_ADDR)) |=> ($stable(mode_o) && $stable(bcd_o))); // R2

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    AST_MODE_FOLDED: assert property (@(posedge clk_i) disable iff (!rst_ni)
      mode_o[c*MODE_W +: MODE_W] <= 3'd5); // R2
  end
endmodule

bind tmr_byte_port tmr_byte_port_chk #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) i_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .wr_en_i(wr_en_i),
  .addr_i (addr_i),
  .rdata_o(rdata_o),
  .ld_o   (ld_o),
  .mode_o (mode_o),
  .bcd_o  (bcd_o)
);

// File: tb/test_tmr_byte_port.sv
module test_tmr_byte_port;
  localparam int NCH = 3;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [1:0]  addr = '0;
  logic [7:0]  wdata = '0;
  logic [7:0]  rdata_o;
  logic [2:0]  ld_o;
  logic [15:0] ld_val_o;
  logic [8:0]  mode_o;
  logic [2:0]  bcd_o;
  logic [15:0] cnt [NCH];
  logic [2:0]  out_v = '0;
  logic [2:0]  loaded = '0;
  logic [47:0] cnt_i;

  int n_vec = 0, n_bad = 0;
  logic       done = 1'b0;
  logic [2:0]  ld_cap;
  logic [15:0] ldv_cap;

  assign cnt_i = {cnt[2], cnt[1], cnt[0]};

  // 8 ns period, 125 MHz
  always #4 clk_i = ~clk_i;

  tmr_byte_port i_tmr_byte_port (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_en_i (wr_en),
    .rd_en_i (rd_en),
    .addr_i  (addr),
    .wdata_i (wdata),
    .rdata_o (rdata_o),
    .ld_o    (ld_o),
    .ld_val_o(ld_val_o),
    .mode_o  (mode_o),
    .bcd_o   (bcd_o),
    .cnt_i   (cnt_i),
    .out_i   (out_v),
    .loaded_i(loaded)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // all tasks start and end just after a falling edge
  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    @(posedge clk_i); #2;
    ld_cap = ld_o; ldv_cap = ld_val_o;
    @(negedge clk_i);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    rd_en = 1'b1; addr = a;
    #1 d = rdata_o;
    @(posedge clk_i);
    @(negedge clk_i);
    rd_en = 1'b0;
  endtask

  task automatic read_status(input int c, output logic [7:0] d);
    wr(2'd3, 8'hE0 | 8'(2 << c));
    rd(2'(c), d);
  endtask

  task automatic pulse_loaded(input logic [2:0] m);
    loaded = m;
    @(negedge clk_i);
    loaded = '0;
  endtask

  task automatic expect_rd(input string req, input logic [1:0] a, input logic [7:0] e);
    logic [7:0] d;
    rd(a, d);
    chk(req, {8'h00, d}, {8'h00, e});
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin : main
    logic [7:0] d;
    for (int c = 0; c < NCH; c++) cnt[c] = '0;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // R1 reset state
    chk("R1 ld", {13'd0, ld_o}, 16'd0);
    chk("R1 mode", {7'd0, mode_o}, 16'd0);
    chk("R1 bcd", {13'd0, bcd_o}, 16'd0);
    expect_rd("R1 addr3", 2'd3, 8'h00);
    for (int c = 0; c < NCH; c++) begin
      read_status(c, d);
      chk("R1 R9 reset status", {8'h00, d}, 16'h0030);
    end

    // exhaustive control-word sweep
    for (int ch = 0; ch < NCH; ch++)
      for (int acc = 1; acc < 4; acc++)
        for (int m = 0; m < 8; m++)
          for (int b = 0; b < 2; b++) begin
            logic [7:0] cw, d1, d2;
            logic [2:0] em;
            cw = {2'(ch), 2'(acc), 3'(m), 1'(b)};
            em = (m > 5) ? 3'(m - 4) : 3'(m);
            out_v[ch] = 1'(m) ^ 1'(b);
            wr(2'd3, cw);
            chk("R2 mode", {13'd0, mode_o[ch*3 +: 3]}, {13'd0, em});
            chk("R2 bcd", {15'd0, bcd_o[ch]}, 16'(b));
            read_status(ch, d);
            chk("R9 R11 status", {8'h00, d}, {8'h00, out_v[ch], 1'b1, 2'(acc), em, 1'(b)});
            d1 = 8'(ch * 64 + m * 8 + b * 3 + acc);
            d2 = ~d1;
            if (acc == 1) begin
              wr(2'(ch), d1);
              chk("R3 lo strobe", {13'd0, ld_cap}, 16'(1 << ch));
              chk("R3 lo value", ldv_cap, {8'h00, d1});
            end else if (acc == 2) begin
              wr(2'(ch), d1);
              chk("R3 hi strobe", {13'd0, ld_cap}, 16'(1 << ch));
              chk("R3 hi value", ldv_cap, {d1, 8'h00});
            end else begin
              wr(2'(ch), d1);
              chk("R4 first byte held", {13'd0, ld_cap}, 16'd0);
              wr(2'(ch), d2);
              chk("R4 word strobe", {13'd0, ld_cap}, 16'(1 << ch));
              chk("R4 word value", ldv_cap, {d2, d1});
            end
            pulse_loaded(3'(1 << ch));
            read_status(ch, d);
            chk("R11 null cleared", {15'd0, d[6]}, 16'd0);
            if (acc == 1) begin
              wr(2'(ch), d2);
              read_status(ch, d);
              chk("R11 null set by load", {15'd0, d[6]}, 16'd1);
              pulse_loaded(3'(1 << ch));
            end
          end

    // live reads and phase handling
    wr(2'd3, 8'h34);  // ch0 word, mode 2
    wr(2'd3, 8'h50);  // ch1 low only
    wr(2'd3, 8'hA0);  // ch2 high only
    cnt[0] = 16'hA55A;
    expect_rd("R5 word lo", 2'd0, 8'h5A);
    wr(2'd0, 8'h11);
    chk("R12 write phase own", {13'd0, ld_cap}, 16'd0);
    expect_rd("R12 read phase own", 2'd0, 8'hA5);
    wr(2'd0, 8'h22);
    chk("R12 word load", ldv_cap, 16'h2211);
    cnt[0] = 16'h1234;
    expect_rd("R5 live lo", 2'd0, 8'h34);
    wr(2'd0, 8'h77);
    wr(2'd3, 8'h34);
    expect_rd("R2 read phase reset", 2'd0, 8'h34);
    wr(2'd3, 8'h34);
    wr(2'd0, 8'h88);
    chk("R2 write phase reset", {13'd0, ld_cap}, 16'd0);
    wr(2'd0, 8'h99);
    chk("R2 write phase reset value", ldv_cap, 16'h9988);
    cnt[1] = 16'hCAFE; cnt[2] = 16'hCAFE;
    expect_rd("R5 lo only", 2'd1, 8'hFE);
    expect_rd("R5 lo only again", 2'd1, 8'hFE);
    expect_rd("R5 hi only", 2'd2, 8'hCA);
    expect_rd("R5 hi only again", 2'd2, 8'hCA);

    // count capture
    wr(2'd3, 8'h34);
    cnt[0] = 16'hBEEF;
    wr(2'd3, 8'h00);
    cnt[0] = 16'h1111;
    wr(2'd3, 8'h00);
    expect_rd("R6 latched lo", 2'd0, 8'hEF);
    wr(2'd3, 8'h00);
    cnt[0] = 16'h3344;
    expect_rd("R6 R7 latched hi", 2'd0, 8'hBE);
    expect_rd("R6 released lo", 2'd0, 8'h44);
    expect_rd("R6 released hi", 2'd0, 8'h33);
    wr(2'd3, 8'h00);
    cnt[0] = 16'h5566;
    expect_rd("R7 relatch lo", 2'd0, 8'h44);
    expect_rd("R7 relatch hi", 2'd0, 8'h33);
    expect_rd("R6 live after", 2'd0, 8'h66);
    cnt[1] = 16'hCAFE;
    wr(2'd3, 8'h40);
    cnt[1] = 16'h0000;
    expect_rd("R6 lo only latch", 2'd1, 8'hFE);
    expect_rd("R6 lo only release", 2'd1, 8'h00);
    cnt[2] = 16'hCAFE;
    wr(2'd3, 8'h80);
    cnt[2] = 16'h0000;
    expect_rd("R6 hi only latch", 2'd2, 8'hCA);
    expect_rd("R6 hi only release", 2'd2, 8'h00);

    // multi-channel snapshot command
    wr(2'd3, 8'h34);  // ch0 word, mode 2
    wr(2'd3, 8'h76);  // ch1 word, mode 3
    wr(2'd3, 8'hB8);  // ch2 word, mode 4
    pulse_loaded(3'b111);
    out_v = 3'b101;
    cnt[0] = 16'h0102; cnt[1] = 16'h0304; cnt[2] = 16'h0506;
    wr(2'd3, 8'hCA);  // count+status, ch0 and ch2
    cnt[0] = 16'hFFFF; cnt[1] = 16'hFFFF; cnt[2] = 16'hFFFF;
    expect_rd("R8 R9 status first", 2'd0, 8'hB4);
    expect_rd("R8 count lo", 2'd0, 8'h02);
    expect_rd("R8 count hi", 2'd0, 8'h01);
    expect_rd("R8 live after", 2'd0, 8'hFF);
    expect_rd("R8 unselected lo", 2'd1, 8'hFF);
    expect_rd("R8 unselected hi", 2'd1, 8'hFF);
    expect_rd("R8 R9 ch2 status", 2'd2, 8'hB8);
    expect_rd("R8 ch2 lo", 2'd2, 8'h06);
    expect_rd("R8 ch2 hi", 2'd2, 8'h05);
    out_v[1] = 1'b0;
    wr(2'd3, 8'hE4);  // status only, ch1
    out_v[1] = 1'b1;
    wr(2'd3, 8'hE4);
    expect_rd("R10 first status kept", 2'd1, 8'h36);
    expect_rd("R10 status read once", 2'd1, 8'hFF);
    cnt[1] = 16'h7788;
    wr(2'd3, 8'hD4);  // count only, ch1
    cnt[1] = 16'h0000;
    expect_rd("R8 count only lo", 2'd1, 8'h88);
    expect_rd("R8 count only hi", 2'd1, 8'h77);
    expect_rd("R1 addr3 end", 2'd3, 8'h00);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule